// File: doc/BRIEF.md
# Micromirror Block Reset Interlock Controller

This block sits between a command source and a micromirror array split into 16 row blocks. It takes one command at a time over a valid/ready handshake: load a block's rows, clear or set a whole block, or fire a mirror reset pulse at one block or at an aligned group of four. For each block it keeps a busy timer that covers the reset pulse and the mirror settling time after it. It exposes that timer as a per-block active flag and a per-block pulse flag.

The controller stops any load, clear or set aimed at a block that is still resetting or settling. It also stops a reset aimed at a block that is active or is being loaded. Commands to any other block go ahead, so data loading overlaps with settling elsewhere in the array. A stalled command holds the port, which keeps commands in order. A block load produces one row strobe per row at a fixed row period. A clear or set produces a single fill strobe. Durations are given in clock cycles: the defaults are 24 pulse cycles, 800 settling cycles (4 µs at 200 MHz), 136 rows per block and 8 cycles per row.

Top module: `mirror_reset_interlock`

## Requirements
- R1: After synchronous reset all active and pulse flags are 0, no row or fill strobe is raised, and a command to an idle array sees `cmd_ready` high.
- R2: A reset command (`cmd_kind` 2'b11) whose `cmd_mode` is not 2'b10 raises the active flag of only the addressed block. The flag rises the cycle after acceptance and stays high for exactly RST_CYC+SETTLE_CYC cycles.
- R3: A reset command with `cmd_mode` 2'b10 raises the active flags of the four blocks whose address bits [3:2] match `cmd_addr[3:2]`. Address bits [1:0] are ignored.
- R4: The pulse flag of a reset block is high for exactly the first RST_CYC cycles of its active window.
- R5: A load (2'b00), clear (2'b01) or set (2'b10) aimed at an active block keeps `cmd_ready` low until that block's active flag has dropped, and is then accepted.
- R6: A command aimed at an idle block is accepted without stall while other blocks are active.
- R7: An accepted load emits ROWS_PER_BLK row strobes, the first in the cycle after acceptance, spaced ROW_CYC cycles apart, with `row_idx` counting up from 0 and `row_blk` equal to `cmd_addr`. `cmd_mode` has no effect on a load.
- R8: While a load is in progress, a further load stalls and a reset aimed at the block being loaded stalls until the load ends. A reset aimed at another idle block is accepted.
- R9: An accepted clear or set raises `fill_stb` for one cycle, in the cycle after acceptance, with `fill_blk` equal to the address and `fill_val` 0 for clear and 1 for set. No earlier load is needed, and `cmd_mode` has no effect.
- R10: A reset whose target set includes an active block stalls until every targeted block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_kind | input | 2 | 00 load, 01 clear, 10 set, 11 reset pulse |
| cmd_mode | input | 2 | Block mode; 2'b10 with a reset selects a four-block group |
| cmd_addr | input | 4 | Target block address |
| blk_active | output | 16 | Per-block busy flag (pulse plus settling) |
| blk_pulse | output | 16 | Per-block reset-pulse phase flag |
| row_stb | output | 1 | One row being loaded this cycle |
| row_blk | output | 4 | Block of the current row strobe |
| row_idx | output | 8 | Row index within the block |
| fill_stb | output | 1 | Block clear/set strobe |
| fill_blk | output | 4 | Block of the fill strobe |
| fill_val | output | 1 | 0 clear, 1 set |

## Verification
Resets are issued in single mode with two different mode values, and in group mode with the low address bits set to non-zero values. This shows whether the mode decode and the group alignment are right, and the flag lengths are measured in each case. Loads, clears and sets are aimed first at idle blocks while other blocks are active, then at active blocks. A stall count of zero against a non-zero count shows whether the interlock is per block rather than global. Reset-versus-load and reset-versus-active overlaps show that the reset path is held off as well. Load and fill commands carry a group mode value, which must not widen their target.

// File: rtl/mbr_pkg.sv
// Package: shared command encodings for the mirror reset interlock.
// Assumes a 2-bit command kind and a 2-bit block mode field.
package mbr_pkg;
    typedef enum logic [1:0] {
        CMD_LOAD  = 2'b00,
        CMD_CLEAR = 2'b01,
        CMD_SET   = 2'b10,
        CMD_RESET = 2'b11
    } cmd_kind_e;

    localparam logic [1:0] MODE_GROUP = 2'b10;
endpackage

// File: rtl/mbr_blk_timer.sv
// Module: per-block busy timer. A start loads pulse+settle cycles; the
// block is active while the count is non-zero and in its pulse phase while
// the count is above the settling length.
// Assumes start_i is only raised for an idle block (checked below).
module mbr_blk_timer #(
    parameter int RST_CYC    = 24,
    parameter int SETTLE_CYC = 800,
    localparam int TOTAL     = RST_CYC + SETTLE_CYC,
    localparam int CNT_W     = $clog2(TOTAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o,
    output logic pulse_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count down the busy window; reload on start.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start_i)       cnt_q <= CNT_W'(TOTAL);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // Decode the active and pulse phases from the count.
    always_comb begin
        active_o = (cnt_q != '0);
        pulse_o  = (cnt_q > CNT_W'(SETTLE_CYC));
    end

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !active_o);

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (pulse_o && active_o));

    // R4
    settle_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_o) |-> (active_o || SETTLE_CYC == 0));
endmodule

// File: rtl/mbr_row_loader.sv
// Module: row-load sequencer. On start it walks every row of one block,
// raising a strobe every ROW_CYC cycles, then returns to idle.
// Assumes start_i is only raised while idle (checked below).
module mbr_row_loader #(
    parameter int NUM_BLK = 16,
    parameter int ROWS    = 136,
    parameter int ROW_CYC = 8,
    localparam int ADDR_W = $clog2(NUM_BLK),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int PH_W   = $clog2(ROW_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] blk_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] blk_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              stb_o
);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(ROW_CYC - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    logic              busy_q;
    logic [ADDR_W-1:0] blk_q;
    logic [ROW_W-1:0]  row_q;
    logic [PH_W-1:0]   ph_q;

    // Sequence rows and phases within the row period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            blk_q  <= '0;
            row_q  <= '0;
            ph_q   <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            blk_q  <= blk_i;
            row_q  <= '0;
            ph_q   <= '0;
        end else if (busy_q) begin
            if (ph_q == PH_LAST) begin
                ph_q <= '0;
                if (row_q == ROW_LAST) busy_q <= 1'b0;
                else                   row_q  <= row_q + 1'b1;
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    // Drive the strobe at the start of each row period.
    always_comb begin
        busy_o = busy_q;
        blk_o  = blk_q;
        row_o  = row_q;
        stb_o  = busy_q && (ph_q == '0);
    end

    // R8
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R7
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(row_o) == ROW_LAST));
endmodule

// File: rtl/mbr_cmd_gate.sv
// Module: command interlock. Decodes the target block set of the current
// command and decides whether it may be accepted against the busy state.
// Assumes one command per cycle; purely combinational.
module mbr_cmd_gate
    import mbr_pkg::*;
#(
    parameter int NUM_BLK = 16,
    parameter int GROUP   = 4,
    localparam int ADDR_W = $clog2(NUM_BLK)
) (
    input  logic [1:0]         kind_i,
    input  logic [1:0]         mode_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_BLK-1:0] active_i,
    input  logic               ld_busy_i,
    input  logic [ADDR_W-1:0]  ld_blk_i,
    output logic [NUM_BLK-1:0] tgt_o,
    output logic               ok_o
);
    cmd_kind_e  kind;
    logic       grp;
    logic       tgt_busy;
    logic       ld_hit;

    // Build the target mask: a single block or an aligned group.
    always_comb begin
        kind = cmd_kind_e'(kind_i);
        grp  = (kind == CMD_RESET) && (mode_i == MODE_GROUP);
        for (int i = 0; i < NUM_BLK; i++) begin
            if (grp) tgt_o[i] = ((i / GROUP) == (int'(addr_i) / GROUP));
            else     tgt_o[i] = (i == int'(addr_i));
        end
    end

    // Decide acceptance from target busy state and loader state.
    always_comb begin
        tgt_busy = |(tgt_o & active_i);
        ld_hit   = ld_busy_i && tgt_o[ld_blk_i];
        unique case (kind)
            CMD_LOAD:  ok_o = !tgt_busy && !ld_busy_i;
            CMD_RESET: ok_o = !tgt_busy && !ld_hit;
            default:   ok_o = !tgt_busy;
        endcase
    end
endmodule

// File: rtl/mirror_reset_interlock.sv
// Module: top of the micromirror block reset interlock. Accepts load,
// clear, set and reset commands, runs a busy timer per block, sequences row
// loads and emits fill strobes, never touching a busy block.
// Assumes a held command keeps its fields stable while stalled.
module mirror_reset_interlock
    import mbr_pkg::*;
#(
    parameter int NUM_BLK    = 16,
    parameter int GROUP      = 4,
    parameter int ROWS       = 136,
    parameter int ROW_CYC    = 8,
    parameter int RST_CYC    = 24,
    parameter int SETTLE_CYC = 800,
    localparam int ADDR_W    = $clog2(NUM_BLK),
    localparam int ROW_W     = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_kind,
    input  logic [1:0]         cmd_mode,
    input  logic [ADDR_W-1:0]  cmd_addr,
    output logic [NUM_BLK-1:0] blk_active,
    output logic [NUM_BLK-1:0] blk_pulse,
    output logic               row_stb,
    output logic [ADDR_W-1:0]  row_blk,
    output logic [ROW_W-1:0]   row_idx,
    output logic               fill_stb,
    output logic [ADDR_W-1:0]  fill_blk,
    output logic               fill_val
);
    logic [NUM_BLK-1:0] tgt;
    logic [NUM_BLK-1:0] rst_start;
    logic               gate_ok;
    logic               cmd_acc;
    logic               ld_start;
    logic               ld_busy;
    cmd_kind_e          kind;

    mbr_cmd_gate #(.NUM_BLK(NUM_BLK), .GROUP(GROUP)) u_gate (
        .kind_i    (cmd_kind),
        .mode_i    (cmd_mode),
        .addr_i    (cmd_addr),
        .active_i  (blk_active),
        .ld_busy_i (ld_busy),
        .ld_blk_i  (row_blk),
        .tgt_o     (tgt),
        .ok_o      (gate_ok)
    );

    // Form the handshake and the per-path start strobes.
    always_comb begin
        kind      = cmd_kind_e'(cmd_kind);
        cmd_ready = gate_ok;
        cmd_acc   = cmd_valid && gate_ok;
        ld_start  = cmd_acc && (kind == CMD_LOAD);
        rst_start = (cmd_acc && kind == CMD_RESET) ? tgt : '0;
    end

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_tmr
        mbr_blk_timer #(.RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (rst_start[b]),
            .active_o (blk_active[b]),
            .pulse_o  (blk_pulse[b])
        );
    end

    mbr_row_loader #(.NUM_BLK(NUM_BLK), .ROWS(ROWS), .ROW_CYC(ROW_CYC)) u_ld (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ld_start),
        .blk_i   (cmd_addr),
        .busy_o  (ld_busy),
        .blk_o   (row_blk),
        .row_o   (row_idx),
        .stb_o   (row_stb)
    );

    // Register the one-cycle clear/set strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_stb <= 1'b0;
            fill_blk <= '0;
            fill_val <= 1'b0;
        end else begin
            fill_stb <= cmd_acc && (kind == CMD_CLEAR || kind == CMD_SET);
            fill_blk <= cmd_addr;
            fill_val <= (kind == CMD_SET);
        end
    end

    // R5
    row_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_stb |-> !blk_active[row_blk]);

    // R5
    fill_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_stb |-> !blk_active[fill_blk]);

    // R3
    group_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_acc && kind == CMD_RESET && cmd_mode == MODE_GROUP)
        |=> ($countones(blk_active & ~$past(blk_active)) == GROUP));

    // R2
    single_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_acc && kind == CMD_RESET && cmd_mode != MODE_GROUP)
        |=> ($countones(blk_active & ~$past(blk_active)) == 1));
endmodule

// File: tb/mirror_reset_interlock_tb_top.sv
`timescale 1ns/1ps
module mirror_reset_interlock_tb_top;
    localparam int NB      = 16;
    localparam int ROWS    = 136;
    localparam int ROW_CYC = 8;
    localparam int RST_CYC = 24;
    localparam int SETTLE  = 800;
    localparam int TOT     = RST_CYC + SETTLE;
    localparam int LDLEN   = ROWS * ROW_CYC;

    localparam logic [1:0] K_LOAD = 2'b00, K_CLR = 2'b01, K_SET = 2'b10, K_RST = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_kind = 2'b00;
    logic [1:0]    cmd_mode = 2'b00;
    logic [3:0]    cmd_addr = 4'd0;
    logic [NB-1:0] blk_active, blk_pulse;
    logic          row_stb, fill_stb, fill_val;
    logic [3:0]    row_blk, fill_blk;
    logic [7:0]    row_idx;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mirror_reset_interlock #(
        .NUM_BLK(NB), .GROUP(4), .ROWS(ROWS), .ROW_CYC(ROW_CYC),
        .RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_mode(cmd_mode), .cmd_addr(cmd_addr),
        .blk_active(blk_active), .blk_pulse(blk_pulse),
        .row_stb(row_stb), .row_blk(row_blk), .row_idx(row_idx),
        .fill_stb(fill_stb), .fill_blk(fill_blk), .fill_val(fill_val)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present a command at a falling edge and hold it until accepted.
    task automatic issue(input logic [1:0] k, input logic [1:0] m, input logic [3:0] a,
                         output int stalls, output logic [NB-1:0] act_acc);
        stalls = 0;
        cmd_kind = k; cmd_mode = m; cmd_addr = a; cmd_valid = 1'b1;
        #1;
        while (!cmd_ready && stalls < 5000) begin
            @(negedge clk); #1;
            stalls++;
        end
        act_acc = blk_active;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && blk_active != '0; i++) @(negedge clk);
    endtask

    // Count active and pulse cycles of one block from the current falling edge.
    task automatic measure(input int idx, output int na, output int np);
        na = 0; np = 0;
        while (blk_active[idx] && na < 5000) begin
            na++;
            if (blk_pulse[idx]) np++;
            @(negedge clk);
        end
    endtask

    // Observe a whole block load starting at the falling edge after acceptance.
    task automatic watch_load(input logic [3:0] blk);
        int nstb = 0, first = -1, last = -1, bad_gap = 0, bad_idx = 0, bad_blk = 0;
        for (int c = 0; c < LDLEN + 8; c++) begin
            if (row_stb) begin
                if (first < 0) first = c;
                else if (c - last != ROW_CYC) bad_gap++;
                if (row_idx != nstb[7:0]) bad_idx++;
                if (row_blk != blk || blk_active[row_blk]) bad_blk++;
                last = c;
                nstb++;
            end
            @(negedge clk);
        end
        chk(nstb == ROWS, "R7 strobe count", nstb, ROWS);
        chk(first == 0, "R7 first strobe cycle", first, 0);
        chk(bad_gap == 0, "R7 strobe spacing errors", bad_gap, 0);
        chk(bad_idx == 0, "R7 row index errors", bad_idx, 0);
        chk(bad_blk == 0, "R7 row block errors", bad_blk, 0);
    endtask

    task automatic t_reset_state();
        chk(blk_active == '0, "R1 active after reset", blk_active, 0);
        chk(blk_pulse == '0, "R1 pulse after reset", blk_pulse, 0);
        chk(!row_stb && !fill_stb, "R1 no strobes", {row_stb, fill_stb}, 0);
        cmd_kind = K_LOAD; cmd_addr = 4'd0; #1;
        chk(cmd_ready, "R1 ready when idle", cmd_ready, 1);
    endtask

    task automatic t_single_reset();
        int s, na, np; logic [NB-1:0] a;
        issue(K_RST, 2'b00, 4'd5, s, a);
        chk(s == 0, "R2 single reset stall", s, 0);
        chk(blk_active == 16'h0020, "R2 single reset flags", blk_active, 16'h0020);
        measure(5, na, np);
        chk(na == TOT, "R2 active length", na, TOT);
        chk(np == RST_CYC, "R4 pulse length", np, RST_CYC);
        issue(K_RST, 2'b11, 4'd9, s, a);
        chk(blk_active == 16'h0200, "R2 mode 11 is single", blk_active, 16'h0200);
        wait_idle();
    endtask

    task automatic t_group_and_fill();
        int s, na, np; logic [NB-1:0] a;
        issue(K_RST, 2'b10, 4'b1110, s, a);
        chk(blk_active == 16'hF000, "R3 group 12-15", blk_active, 16'hF000);
        issue(K_CLR, 2'b10, 4'd0, s, a);
        chk(s == 0, "R6 clear idle block during group", s, 0);
        chk(fill_stb && fill_blk == 4'd0 && !fill_val, "R9 clear strobe",
            {fill_stb, fill_blk, fill_val}, {1'b1, 4'd0, 1'b0});
        @(negedge clk);
        chk(!fill_stb, "R9 fill strobe one cycle", fill_stb, 0);
        issue(K_SET, 2'b00, 4'd12, s, a);
        chk(s > 0, "R5 set to active block stalls", s, 1);
        chk(a[12] == 1'b0, "R5 set accepted after drop", a[12], 0);
        chk(fill_stb && fill_blk == 4'd12 && fill_val, "R9 set strobe",
            {fill_stb, fill_blk, fill_val}, {1'b1, 4'd12, 1'b1});
        issue(K_RST, 2'b10, 4'b0111, s, a);
        chk(blk_active == 16'h00F0, "R3 group 4-7 low bits ignored", blk_active, 16'h00F0);
        measure(7, na, np);
        chk(na == TOT - 0, "R3 group active length", na, TOT);
        wait_idle();
    endtask

    task automatic t_load_during_reset();
        int s; logic [NB-1:0] a;
        issue(K_RST, 2'b10, 4'b0011, s, a);
        chk(blk_active == 16'h000F, "R3 group 0-3", blk_active, 16'h000F);
        issue(K_LOAD, 2'b10, 4'd8, s, a);
        chk(s == 0, "R6 load idle block during group", s, 0);
        chk(blk_active[8] == 1'b0 && blk_active[3:0] != '0, "R7 mode ignored on load",
            blk_active, 16'h000F);
        watch_load(4'd8);
        wait_idle();
    endtask

    task automatic t_load_on_active();
        int s; logic [NB-1:0] a;
        issue(K_RST, 2'b00, 4'd4, s, a);
        issue(K_LOAD, 2'b00, 4'd4, s, a);
        chk(s > 0, "R5 load to active block stalls", s, 1);
        chk(a[4] == 1'b0, "R5 load accepted after drop", a[4], 0);
        watch_load(4'd4);
    endtask

    task automatic t_load_interlock();
        int s; logic [NB-1:0] a;
        issue(K_LOAD, 2'b00, 4'd6, s, a);
        issue(K_RST, 2'b00, 4'd9, s, a);
        chk(s == 0, "R8 reset other block during load", s, 0);
        issue(K_RST, 2'b00, 4'd6, s, a);
        chk(s >= LDLEN - 2, "R8 reset of loading block stalls", s, LDLEN - 1);
        chk(blk_active[6], "R8 reset accepted after load", blk_active[6], 1);
        wait_idle();
        issue(K_LOAD, 2'b00, 4'd1, s, a);
        issue(K_LOAD, 2'b00, 4'd2, s, a);
        chk(s >= LDLEN - 2, "R8 second load stalls", s, LDLEN - 1);
        watch_load(4'd2);
    endtask

    task automatic t_reset_on_active();
        int s; logic [NB-1:0] a;
        issue(K_RST, 2'b00, 4'd2, s, a);
        issue(K_RST, 2'b10, 4'd1, s, a);
        chk(s > 0, "R10 group reset over active block stalls", s, 1);
        chk(a[3:0] == 4'h0, "R10 targets idle at accept", a[3:0], 0);
        chk(blk_active == 16'h000F, "R10 group flags after accept", blk_active, 16'h000F);
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_single_reset();
        t_group_and_fill();
        t_load_during_reset();
        t_load_on_active();
        t_load_interlock();
        t_reset_on_active();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule